// File: doc/BRIEF.md
# Memory-Resident Three-Cycle Break Transfer Engine

This block moves single 12-bit words between a peripheral and main memory by taking memory cycles away from the processor. The per-channel bookkeeping is held in main memory, not in the peripheral. Each channel owns two consecutive memory words: a negative word count and a transfer pointer. When a device asks for a break, the engine runs three memory cycles in a row. First it increments the count. Next it increments the pointer. Last it writes the device's word to the pointed location, or reads that location out to the device.

A request is accepted only while the processor marks a boundary between its own memory cycles. The processor is held off for the three stolen cycles. The engine acknowledges the device during the data cycle. In that same cycle it raises an overflow flag if the count has just reached zero, which tells the device the block is finished. The pointer is incremented before it is used, so software loads it with one less than the first buffer address.

States: `ST_IDLE` (waiting), `ST_COUNT` (count update), `ST_ADDR` (pointer update), `ST_XFER` (data move). Transitions:
- `ST_IDLE`→`ST_COUNT` when a request meets a cycle boundary.
- `ST_IDLE`→`ST_IDLE` otherwise.
- `ST_COUNT`→`ST_ADDR`, `ST_ADDR`→`ST_XFER` and `ST_XFER`→`ST_IDLE` happen unconditionally.

Top module: `dbrk_engine`

## Requirements
- R1: After reset, `cpu_hold`, `brk_ack`, `brk_ovf` and `mem_we` are all low.
- R2: A break starts only on a clock edge where both `brk_req` and `cpu_cycle_end` are high. Until then `cpu_hold`, `brk_ack` and `mem_we` stay low.
- R3: In the first stolen cycle, `mem_addr` is PTR_BASE + 2*channel (default PTR_BASE = 24). `mem_we` is high, and `mem_wdata` is the word read there plus one, modulo 4096.
- R4: In the second stolen cycle, `mem_addr` is PTR_BASE + 2*channel + 1. `mem_we` is high, and `mem_wdata` is the word read there plus one, modulo 4096.
- R5: In the third stolen cycle, `mem_addr` equals the pointer value written in the second cycle. `brk_ack` is high in this cycle only.
- R6: For the input direction (`brk_dir_in`=1 when the request is taken), the third cycle has `mem_we` high with `mem_wdata` equal to `dev_wdata`.
- R7: For the output direction (`brk_dir_in`=0), the third cycle has `mem_we` low, and `dev_rdata` equals the memory word at the pointed location.
- R8: `brk_ovf` is high in the third cycle exactly when the count written in the first cycle is zero. It is low at all other times.
- R9: A pointer of 4095 increments to 0, so the data word goes to or from address 0.
- R10: `cpu_hold` is high for exactly the three stolen cycles of each break and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_cycle_end | input | 1 | Processor is between memory cycles |
| cpu_hold | output | 1 | Processor held off during a break |
| brk_req | input | 1 | Device break request |
| brk_chan | input | CH_W (2) | Channel number of the request |
| brk_dir_in | input | 1 | 1 = device to memory, 0 = memory to device |
| dev_wdata | input | 12 | Word from the device (input direction) |
| dev_rdata | output | 12 | Word to the device (output direction, data cycle) |
| brk_ack | output | 1 | Pulse in the data cycle |
| brk_ovf | output | 1 | Word count reached zero on this transfer |
| mem_addr | output | 12 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data for `mem_addr`, same cycle |

## Verification
The bench targets these corner cases:
- A request held while the processor is mid-cycle. A design that ignored the boundary would steal cycles early.
- A count starting at zero. This must not overflow, whereas a design that tested the pre-increment value would flag it.
- A count starting at -1. This must overflow on its single word.
- A pointer of 4095. It must wrap to address 0 rather than carry into a wider value.
- Back-to-back breaks on different channels with both directions. A design that reused the previous channel's pointer pair or direction, or kept `cpu_hold` high one cycle too long, would show up as a mismatch against the behavioural model on the very cycle it happened.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
    localparam int WORD_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ADDR  = 2'd2,
        ST_XFER  = 2'd3
    } brk_state_e;

    typedef struct packed {
        logic count;
        logic addr;
        logic xfer;
        logic busy;
    } brk_phase_t;
endpackage

// File: rtl/dbrk_sequencer.sv
module dbrk_sequencer
    import dbrk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output brk_phase_t phase
);
    brk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_COUNT;
            ST_COUNT: state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_XFER;
            ST_XFER:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        phase = '0;
        unique case (state_q)
            ST_IDLE:  phase = '0;
            ST_COUNT: begin phase.count = 1'b1; phase.busy = 1'b1; end
            ST_ADDR:  begin phase.addr  = 1'b1; phase.busy = 1'b1; end
            ST_XFER:  begin phase.xfer  = 1'b1; phase.busy = 1'b1; end
            default:  phase = '0;
        endcase
    end
endmodule

// File: rtl/dbrk_ptr_unit.sv
module dbrk_ptr_unit #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_count,
    input  logic              in_addr,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] inc_word,
    output logic [WORD_W-1:0] cur_ptr,
    output logic              last_word
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    // modular increment shared by both bookkeeping cycles
    assign inc_word = rd_word + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ptr   <= '0;
            last_word <= 1'b0;
        end else begin
            if (in_count) last_word <= (inc_word == '0);
            if (in_addr)  cur_ptr   <= inc_word;
        end
    end
endmodule

// File: rtl/dbrk_addr_mux.sv
module dbrk_addr_mux #(
    parameter int                WORD_W   = 12,
    parameter int                CHANNELS = 4,
    parameter logic [WORD_W-1:0] PTR_BASE = 12'd24
) (
    input  logic [$clog2(CHANNELS)-1:0] chan,
    input  logic                        in_count,
    input  logic                        in_addr,
    input  logic [WORD_W-1:0]           cur_ptr,
    output logic [WORD_W-1:0]           addr
);
    localparam int CH_W  = $clog2(CHANNELS);
    localparam int PAD_W = WORD_W - CH_W - 1;

    logic [WORD_W-1:0] pair_base;

    generate
        if (PAD_W > 0) begin : g_pad
            assign pair_base = PTR_BASE + {{PAD_W{1'b0}}, chan, 1'b0};
        end else begin : g_nopad
            assign pair_base = PTR_BASE + WORD_W'({chan, 1'b0});
        end
    endgenerate

    always_comb begin
        if (in_count)     addr = pair_base;
        else if (in_addr) addr = pair_base | WORD_W'(1);
        else              addr = cur_ptr;
    end
endmodule

// File: rtl/dbrk_engine.sv
module dbrk_engine
    import dbrk_pkg::*;
#(
    parameter int                CHANNELS = 4,
    parameter logic [WORD_W-1:0] PTR_BASE = 12'd24,
    localparam int               CH_W     = $clog2(CHANNELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cycle_end,
    output logic              cpu_hold,
    input  logic              brk_req,
    input  logic [CH_W-1:0]   brk_chan,
    input  logic              brk_dir_in,
    input  logic [WORD_W-1:0] dev_wdata,
    output logic [WORD_W-1:0] dev_rdata,
    output logic              brk_ack,
    output logic              brk_ovf,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    brk_phase_t        phase;
    logic              start;
    logic [CH_W-1:0]   chan_q;
    logic              dir_q;
    logic [WORD_W-1:0] inc_word;
    logic [WORD_W-1:0] cur_ptr;
    logic              last_word;

    assign start = brk_req & cpu_cycle_end & ~phase.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            dir_q  <= 1'b0;
        end else if (start) begin
            chan_q <= brk_chan;
            dir_q  <= brk_dir_in;
        end
    end

    dbrk_sequencer u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .phase (phase)
    );

    dbrk_ptr_unit #(.WORD_W(WORD_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_count  (phase.count),
        .in_addr   (phase.addr),
        .rd_word   (mem_rdata),
        .inc_word  (inc_word),
        .cur_ptr   (cur_ptr),
        .last_word (last_word)
    );

    dbrk_addr_mux #(
        .WORD_W   (WORD_W),
        .CHANNELS (CHANNELS),
        .PTR_BASE (PTR_BASE)
    ) u_addr (
        .chan     (chan_q),
        .in_count (phase.count),
        .in_addr  (phase.addr),
        .cur_ptr  (cur_ptr),
        .addr     (mem_addr)
    );

    assign cpu_hold  = phase.busy;
    assign brk_ack   = phase.xfer;
    assign brk_ovf   = phase.xfer & last_word;
    assign mem_we    = phase.count | phase.addr | (phase.xfer & dir_q);
    assign mem_wdata = phase.xfer ? dev_wdata : inc_word;
    assign dev_rdata = (phase.xfer & ~dir_q) ? mem_rdata : '0;
endmodule

// File: rtl/dbrk_checker.sv
module dbrk_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_cycle_end,
    input logic brk_req,
    input logic cpu_hold,
    input logic brk_ack,
    input logic brk_ovf,
    input logic mem_we
);
    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_hold) |-> $past(brk_req && cpu_cycle_end));

    p_three_cycles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_ack |-> (cpu_hold && $past(cpu_hold) && $past(cpu_hold, 2)));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_ack |=> !cpu_hold);

    p_hold_ends_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_hold) |-> $past(brk_ack));

    p_ovf_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_ovf |-> brk_ack);

    p_we_in_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cpu_hold);
endmodule

bind dbrk_engine dbrk_checker u_dbrk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_cycle_end (cpu_cycle_end),
    .brk_req       (brk_req),
    .cpu_hold      (cpu_hold),
    .brk_ack       (brk_ack),
    .brk_ovf       (brk_ovf),
    .mem_we        (mem_we)
);

// File: tb/dbrk_engine_bench.sv
`timescale 1ns/1ps
module dbrk_engine_bench;
    localparam int BASE = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cycle_end = 1'b0;
    logic        cpu_hold;
    logic        brk_req = 1'b0;
    logic [1:0]  brk_chan = '0;
    logic        brk_dir_in = 1'b0;
    logic [11:0] dev_wdata = '0;
    logic [11:0] dev_rdata;
    logic        brk_ack;
    logic        brk_ovf;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata;

    logic [11:0] dmem [4096];
    int          refm [4096];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dbrk_engine u_dbrk_engine (.*);

    assign mem_rdata = dmem[mem_addr];
    always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: phase counter plus its own memory image
    int ph = 0, mch = 0, mca = 0, a = 0, v = 0;
    bit mdir = 0, mflag = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            case (ph)
                0: begin
                    chk("R2 hold", cpu_hold, 0);
                    chk("R2 ack", brk_ack, 0);
                    chk("R2 we", mem_we, 0);
                    chk("R8 ovf idle", brk_ovf, 0);
                    if (brk_req && cpu_cycle_end) begin
                        ph = 1; mch = brk_chan; mdir = brk_dir_in;
                    end
                end
                1, 2: begin
                    a = BASE + 2 * mch + ph - 1;
                    v = (refm[a] + 1) & 12'hfff;
                    chk(ph == 1 ? "R3 addr" : "R4 addr", mem_addr, a);
                    chk(ph == 1 ? "R3 we" : "R4 we", mem_we, 1);
                    chk(ph == 1 ? "R3 wdata" : "R4 wdata", mem_wdata, v);
                    chk("R10 hold", cpu_hold, 1);
                    chk("R5 ack early", brk_ack, 0);
                    chk("R8 ovf early", brk_ovf, 0);
                    refm[a] = v;
                    if (ph == 1) mflag = (v == 0); else mca = v;
                    ph = ph + 1;
                end
                default: begin
                    chk(mca == 0 ? "R9 wrap addr" : "R5 addr", mem_addr, mca);
                    chk("R5 ack", brk_ack, 1);
                    chk("R10 hold", cpu_hold, 1);
                    chk("R8 ovf", brk_ovf, int'(mflag));
                    if (mdir) begin
                        chk("R6 we", mem_we, 1);
                        chk("R6 wdata", mem_wdata, dev_wdata);
                        refm[mca] = dev_wdata;
                    end else begin
                        chk("R7 we", mem_we, 0);
                        chk("R7 rdata", dev_rdata, refm[mca]);
                    end
                    ph = 0;
                end
            endcase
        end
    end

    task automatic brk(input int ch, input bit din, input int w);
        @(posedge clk); #1;
        brk_req = 1'b1; brk_chan = 2'(ch); brk_dir_in = din; dev_wdata = 12'(w);
        do @(negedge clk); while (!brk_ack);
        @(posedge clk); #1;
        brk_req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            dmem[i] = 12'((i * 5 + 7) & 12'hfff);
            refm[i] = int'(dmem[i]);
        end
        // channel pointer pairs: count, pointer
        dmem[24] = 12'd4093; dmem[25] = 12'd99;
        dmem[26] = 12'd4094; dmem[27] = 12'd4095;
        dmem[28] = 12'd0;    dmem[29] = 12'd200;
        dmem[30] = 12'd4095; dmem[31] = 12'd500;
        for (int i = 24; i < 32; i++) refm[i] = int'(dmem[i]);

        repeat (3) @(negedge clk);
        chk("R1 hold", cpu_hold, 0);
        chk("R1 ack", brk_ack, 0);
        chk("R1 ovf", brk_ovf, 0);
        chk("R1 we", mem_we, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2: request held while processor is mid-cycle
        @(posedge clk); #1 brk_req = 1'b1; brk_chan = 2'd0; brk_dir_in = 1'b1; dev_wdata = 12'o1234;
        repeat (4) @(posedge clk);
        #1 brk_req = 1'b0; cpu_cycle_end = 1'b1;

        brk(0, 1, 12'o1234);   // R6 input
        brk(1, 0, 0);          // R9 pointer 4095 -> 0, R7 output
        brk(0, 1, 12'o7777);
        brk(2, 1, 12'o0055);   // count 0 -> 1, no overflow (R8)
        brk(3, 0, 0);          // count -1 -> 0, overflow (R8)
        brk(1, 0, 0);          // second word, overflow
        brk(0, 1, 12'o0001);   // third word, overflow

        // boundary toggling between breaks
        cpu_cycle_end = 1'b0;
        @(posedge clk); #1 brk_req = 1'b1; brk_chan = 2'd2; brk_dir_in = 1'b0;
        repeat (2) @(posedge clk);
        #1 cpu_cycle_end = 1'b1;
        do @(negedge clk); while (!brk_ack);
        @(posedge clk); #1 brk_req = 1'b0;
        brk(3, 1, 12'o4321);
        repeat (4) @(posedge clk);

        // final memory image (R6)
        begin
            int bad = 0;
            for (int i = 0; i < 4096; i++) if (int'(dmem[i]) != refm[i]) bad++;
            chk("R6 memory image mismatches", bad, 0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule